// File: doc/BRIEF.md
# BCD Seven-Segment Latch Decoder

This block turns a four-bit binary-coded decimal digit into the seven segment drives of a single display digit. A capture register in front of the decoder either follows the incoming code on every clock edge or freezes the last accepted code, so a shared data bus can be time-multiplexed across several digits, each loading only when its load enable is high.

Two output controls act combinationally on the decoded pattern. A blank control turns every segment off. An invert control flips the polarity of all seven outputs. Toggling the invert control with the same square wave that drives a liquid-crystal backplane gives each segment the AC drive it needs: a lit segment is always out of phase with the backplane, and a dark segment is always in phase with it. Codes above nine show nothing.

Top module: `bcd_seg_latch_decoder`

## Requirements
- R1: While `load_en` is high at a rising clock edge, the capture register takes `bcd_in`, and `seg_out` shows that code from just after that edge. It does not show it before the edge.
- R2: While `load_en` is low, the held code is kept unchanged across clock edges, whatever values `bcd_in` takes, including while the display is blanked.
- R3: A high `rst` at a rising edge (synchronous, active high) sets the held code to 0, so `seg_out` shows the digit 0 pattern when both output controls are low.
- R4: Output bit order is `seg_out[0]`=a (top), [1]=b (upper right), [2]=c (lower right), [3]=d (bottom), [4]=e (lower left), [5]=f (upper left), [6]=g (middle). A 1 means lit when `invert_en` is low. Digits 0..9 give the hex patterns 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F. So 6 includes a, 9 includes d, 7 is a,b,c only, and 1 is b,c only.
- R5: Held codes 10 through 15 give all segments off (00 with `invert_en` low).
- R6: When `blank_en` is high, all segments are off (00 with `invert_en` low), whatever the held code, `bcd_in` or `load_en`. This takes effect in the same cycle, with no register stage.
- R7: When `invert_en` is high, every output bit is the complement of its value with `invert_en` low. This includes blank patterns (7F). It takes effect in the same cycle.
- R8: The code has 8-4-2-1 weighting, with `bcd_in[0]` as the weight-1 bit and `bcd_in[3]` as the weight-8 bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bcd_in | input | 4 | BCD digit code, bit 0 has weight 1 |
| load_en | input | 1 | High: capture `bcd_in` each edge; low: hold |
| blank_en | input | 1 | High: all segments off |
| invert_en | input | 1 | High: complement all segment outputs |
| seg_out | output | 7 | Segment drives, bit 0 = a through bit 6 = g |

## Verification
The hardest situation to reach is a held code staying intact while `bcd_in` wanders and the display is blanked. The blank hides the very state under test. The stimulus loads a digit, drops `load_en`, and pushes both valid and invalid codes onto `bcd_in` over several edges with blanking on. It then releases the blank and checks that the original digit reappears, in both polarities. Every one of the sixteen codes is also loaded and viewed under all four blank/invert combinations.

// File: rtl/bcdseg_pkg.sv
package bcdseg_pkg;
  localparam int CODE_W = 4;
  localparam int SEG_W  = 7;
  localparam int DIGITS = 10;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [SEG_W-1:0]  seg_t;
endpackage

// File: rtl/bcdseg_capture.sv
module bcdseg_capture #(
  parameter int W = bcdseg_pkg::CODE_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)          q <= '0;
    else if (load_en) q <= d;
  end

  // R1: a loading edge takes the presented code
  assert_load_takes_R1: assert property (@(posedge clk) disable iff (rst)
    load_en |=> (q == $past(d)));

  // R2: no loading edge, no change
  assert_hold_stable_R2: assert property (@(posedge clk) disable iff (rst)
    !load_en |=> $stable(q));
endmodule

// File: rtl/bcdseg_decode.sv
module bcdseg_decode
  import bcdseg_pkg::*;
(
  input  code_t code,
  output seg_t  glyph
);
  // bit order g f e d c b a
  always_comb begin
    unique case (code)
      4'd0:    glyph = 7'b0111111;
      4'd1:    glyph = 7'b0000110;
      4'd2:    glyph = 7'b1011011;
      4'd3:    glyph = 7'b1001111;
      4'd4:    glyph = 7'b1100110;
      4'd5:    glyph = 7'b1101101;
      4'd6:    glyph = 7'b1111101;
      4'd7:    glyph = 7'b0000111;
      4'd8:    glyph = 7'b1111111;
      4'd9:    glyph = 7'b1101111;
      default: glyph = 7'b0000000;
    endcase
  end
endmodule

// File: rtl/bcdseg_drive.sv
module bcdseg_drive #(
  parameter int W = bcdseg_pkg::SEG_W
) (
  input  logic [W-1:0] glyph,
  input  logic         blank_en,
  input  logic         invert_en,
  output logic [W-1:0] seg
);
  for (genvar i = 0; i < W; i++) begin : g_seg
    assign seg[i] = (glyph[i] & ~blank_en) ^ invert_en;
  end
endmodule

// File: rtl/bcd_seg_latch_decoder.sv
module bcd_seg_latch_decoder
  import bcdseg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] bcd_in,
  input  logic              load_en,
  input  logic              blank_en,
  input  logic              invert_en,
  output logic [SEG_W-1:0]  seg_out
);
  code_t code_q;
  seg_t  glyph;

  bcdseg_capture #(.W(CODE_W)) capture_i (
    .clk(clk), .rst(rst), .load_en(load_en), .d(bcd_in), .q(code_q)
  );

  bcdseg_decode decode_i (.code(code_q), .glyph(glyph));

  bcdseg_drive #(.W(SEG_W)) drive_i (
    .glyph(glyph), .blank_en(blank_en), .invert_en(invert_en), .seg(seg_out)
  );

  // R6: blank forces all segments dark in true polarity
  assert_blank_dark_R6: assert property (@(posedge clk) disable iff (rst)
    (blank_en && !invert_en) |-> (seg_out == '0));

  // R7: blank in inverted polarity drives every output high
  assert_blank_inverted_R7: assert property (@(posedge clk) disable iff (rst)
    (blank_en && invert_en) |-> (seg_out == '1));

  // R5: codes above nine show nothing
  assert_invalid_blank_R5: assert property (@(posedge clk) disable iff (rst)
    (code_q > code_t'(DIGITS-1) && !invert_en) |-> (seg_out == '0));

  // R4: a valid digit always lights at least two segments
  assert_digit_lit_R4: assert property (@(posedge clk) disable iff (rst)
    (code_q <= code_t'(DIGITS-1) && !blank_en && !invert_en)
      |-> ($countones(seg_out) >= 2));

  // R4: eight lights everything; inverted, it lights nothing
  assert_eight_full_R4: assert property (@(posedge clk) disable iff (rst)
    (code_q == code_t'(8) && !blank_en && invert_en) |-> (seg_out == '0));
endmodule

// File: tb/bcd_seg_latch_decoder_tb_top.sv
`timescale 1ns/1ps
module bcd_seg_latch_decoder_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] bcd_in;
  logic       load_en, blank_en, invert_en;
  logic [6:0] seg_out;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  bcd_seg_latch_decoder dut_i (
    .clk(clk), .rst(rst), .bcd_in(bcd_in), .load_en(load_en),
    .blank_en(blank_en), .invert_en(invert_en), .seg_out(seg_out)
  );

  function automatic logic [6:0] glyph_of(int code);
    case (code)
      0: return 7'h3F;  1: return 7'h06;  2: return 7'h5B;  3: return 7'h4F;
      4: return 7'h66;  5: return 7'h6D;  6: return 7'h7D;  7: return 7'h07;
      8: return 7'h7F;  9: return 7'h6F;
      default: return 7'h00;
    endcase
  endfunction

  function automatic logic [6:0] expect_seg(int code, logic blank, logic inv);
    logic [6:0] v;
    v = blank ? 7'h00 : glyph_of(code);
    return inv ? ~v : v;
  endfunction

  task automatic check(string req, logic [6:0] act, logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: seg_out=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_code(int code);
    @(negedge clk);
    bcd_in = 4'(code);
    load_en = 1'b1;
    @(posedge clk);
    #1;
    load_en = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1; load_en = 1'b1; bcd_in = 4'd7; blank_en = 1'b0; invert_en = 1'b0;
    @(posedge clk); #1;
    load_en = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R3 reset shows digit 0", seg_out, 7'h3F);
  endtask

  task automatic t_all_codes();
    for (int c = 0; c < 16; c++) begin
      load_code(c);
      for (int m = 0; m < 4; m++) begin
        blank_en = m[0];
        invert_en = m[1];
        #1;
        if (m[0])      check("R6/R7 blank", seg_out, expect_seg(c, 1'b1, m[1]));
        else if (c > 9) check("R5/R7 invalid code", seg_out, expect_seg(c, 1'b0, m[1]));
        else            check("R4/R7/R8 digit", seg_out, expect_seg(c, 1'b0, m[1]));
      end
      blank_en = 1'b0;
      invert_en = 1'b0;
    end
  endtask

  task automatic t_hold();
    load_code(3);
    blank_en = 1'b1;
    foreach (bcd_in[i]) begin end
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      bcd_in = (k == 0) ? 4'd8 : (k == 1) ? 4'd12 : (k == 2) ? 4'd5 : 4'd15;
      @(posedge clk); #1;
      check("R2/R6 blanked during hold", seg_out, 7'h00);
    end
    blank_en = 1'b0;
    #1;
    check("R2 held code after blank", seg_out, 7'h4F);
    invert_en = 1'b1;
    #1;
    check("R2/R7 held code inverted", seg_out, 7'h30);
    invert_en = 1'b0;
    @(negedge clk);
    bcd_in = 4'd9;
    load_en = 1'b1;
    #1;
    check("R1 no change before edge", seg_out, 7'h4F);
    @(posedge clk); #1;
    check("R1 load after edge", seg_out, 7'h6F);
    load_en = 1'b0;
  endtask

  task automatic t_weights();
    for (int b = 0; b < 4; b++) begin
      load_code(1 << b);
      #1;
      check("R8 single weight bit", seg_out, expect_seg(1 << b, 1'b0, 1'b0));
    end
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: seg_out=%h expected=completion", seg_out);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; bcd_in = '0; load_en = 1'b0; blank_en = 1'b0; invert_en = 1'b0;
    t_reset();
    t_all_codes();
    t_hold();
    t_weights();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule